// File: doc/BRIEF.md
# Master-Slave PWM Timer Pair

The block joins two 16-bit down-counting channels so that together they drive one pulse-width-modulated output. The master channel fixes the period: it counts down from a period value and, each time it passes zero, it reloads and raises a one-cycle interrupt pulse, called a tick here. The slave channel fixes the duty: every tick reloads it with a duty value, and the output stays at its active level while the slave count is non-zero. Once the slave has counted out it parks at zero until the next tick.

Software writes the period and duty values. It starts and stops both channels together with single-cycle trigger strobes, and it can read both live counters at any time. A configuration write sets the output polarity, the output-enable, and the level that the pin shows while the output-enable is off. Counting advances only on cycles where the count-clock enable is high. Start and stop are software events and act on the cycle they are applied.

Top module: `pwm_pair_timer`

## Requirements
- R1: A synchronous reset clears both counters, the period and duty values, the interrupt pulse, the output-enable, the polarity and the software level, and leaves both channels stopped. Until a start, the counters do not move, even with the count-clock enable high.
- R2: A start strobe (without a stop strobe in the same cycle) loads the master counter with the written period value and the slave counter with the written duty value. In the next cycle it raises the master interrupt pulse for exactly one cycle.
- R3: While running, the master counter decrements once per cycle with the count-clock enable high and holds on other cycles. On an enabled cycle at count 0 it reloads and pulses the interrupt in the next cycle, so one PWM period lasts P+1 count clocks for period value P.
- R4: On every master tick the slave counter loads the duty value. It then decrements on enabled cycles while running, and it holds at 0 once it gets there until the next tick.
- R5: The output is at its active level exactly while the slave counter is non-zero, which starts in the cycle after the tick. Duty D with D <= P gives D active count clocks per period. D = 0 gives a constantly inactive output, and D > P gives a constantly active output.
- R6: Period and duty values written while running are captured at the next master tick. They are used first by the reload at the tick after that one.
- R7: A stop strobe halts both channels. Both counters and the output level then hold. A stop strobe in the same cycle as a start strobe wins, and nothing starts.
- R8: With the polarity bit at 0 the active level is high (1). With it at 1 the active level is low (0).
- R9: With the output-enable at 0, the output shows the software level last written by a configuration write. The output-enable pin shows the output-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-clock enable; counters advance on cycles where it is high |
| start_req | input | 1 | Start strobe for both channels, one cycle |
| stop_req | input | 1 | Stop strobe for both channels, one cycle; wins over start |
| per_wr | input | 1 | Period value write strobe |
| per_wdata | input | 16 | Period value |
| duty_wr | input | 1 | Duty value write strobe |
| duty_wdata | input | 16 | Duty value |
| cfg_wr | input | 1 | Output configuration write strobe |
| cfg_oe | input | 1 | Output-enable bit |
| cfg_pol | input | 1 | Polarity bit (1 = active low) |
| cfg_lvl | input | 1 | Software level shown while output-enable is 0 |
| mst_count | output | 16 | Live master counter |
| slv_count | output | 16 | Live slave counter |
| mst_irq | output | 1 | One-cycle master interrupt pulse |
| pwm_out | output | 1 | PWM output level |
| pwm_oe | output | 1 | Output-enable |

## Verification
A behavioural model runs beside the design on every cycle. It is driven first with a steady count-clock enable and a mid-range duty, where the active-cycle count per period shows the reload-to-zero distance is right. It is then driven with an irregular enable pattern, which separates counting on enabled cycles from counting on every clock. Duty values of zero and above the period probe both saturated ends of the output. A period rewrite in mid-run, timed by the gap between interrupts, shows whether the new value lands one tick too early. Stop, stop-with-start, inverted polarity and the software level are each checked at the pins.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;

  typedef struct packed {
    logic oe;
    logic pol;
    logic lvl;
  } out_cfg_t;

  // Pin level from the slave activity and the output configuration.
  function automatic logic pin_level(input logic active, input out_cfg_t c);
    return c.oe ? (active ^ c.pol) : c.lvl;
  endfunction

endpackage

// File: rtl/pwm_master_ch.sv
`timescale 1ns/1ps
module pwm_master_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         start_go,
  input  logic         stop_req,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  output logic [W-1:0] cnt,
  output logic         run,
  output logic         zero_tick,
  output logic         tick,
  output logic         irq
);

  logic [W-1:0] per_q;    // software-written period
  logic [W-1:0] per_act;  // period used by the zero reload

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c,
                                             input logic [W-1:0] reload);
    return (c == '0) ? reload : c - 1'b1;
  endfunction

  assign zero_tick = run && en && (cnt == '0);
  assign tick      = start_go || zero_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      run     <= 1'b0;
      irq     <= 1'b0;
      per_q   <= '0;
      per_act <= '0;
    end else begin
      irq <= tick;
      if (per_wr) per_q <= per_wdata;
      if (start_go)       cnt <= per_q;
      else if (run && en) cnt <= step_down(cnt, per_act);
      if (tick) per_act <= per_q;
      if (stop_req)      run <= 1'b0;
      else if (start_go) run <= 1'b1;
    end
  end

endmodule

// File: rtl/pwm_slave_ch.sv
`timescale 1ns/1ps
module pwm_slave_ch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         run,
  input  logic         start_go,
  input  logic         zero_tick,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] load_val,
  output logic         active
);

  logic [W-1:0] duty_q;
  logic [W-1:0] duty_act;

  assign load_val = start_go ? duty_q : duty_act;
  assign active   = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      duty_q   <= '0;
      duty_act <= '0;
    end else begin
      if (duty_wr) duty_q <= duty_wdata;
      if (start_go || zero_tick) begin
        cnt      <= load_val;
        duty_act <= duty_q;
      end else if (run && en && active) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage
  import pwm_pair_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_wr,
  input  out_cfg_t cfg_in,
  input  logic     active,
  output logic     pin,
  output logic     pin_oe
);

  out_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_in;
  end

  assign pin    = pin_level(active, cfg_q);
  assign pin_oe = cfg_q.oe;

endmodule

// File: rtl/pwm_pair_timer.sv
`timescale 1ns/1ps
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W-1:0] duty_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_oe,
  input  logic             cfg_pol,
  input  logic             cfg_lvl,
  output logic [CNT_W-1:0] mst_count,
  output logic [CNT_W-1:0] slv_count,
  output logic             mst_irq,
  output logic             pwm_out,
  output logic             pwm_oe
);

  logic             start_go_w;
  logic             run_w;
  logic             ztick_w;
  logic             tick_w;
  logic             active_w;
  logic [CNT_W-1:0] slv_ld_w;
  out_cfg_t         cfg_w;

  assign start_go_w = start_req && !stop_req;
  assign cfg_w      = '{oe: cfg_oe, pol: cfg_pol, lvl: cfg_lvl};

  pwm_master_ch #(.W(CNT_W)) u_mst (
    .clk(clk), .rst(rst), .en(cnt_en), .start_go(start_go_w),
    .stop_req(stop_req), .per_wr(per_wr), .per_wdata(per_wdata),
    .cnt(mst_count), .run(run_w), .zero_tick(ztick_w), .tick(tick_w),
    .irq(mst_irq)
  );

  pwm_slave_ch #(.W(CNT_W)) u_slv (
    .clk(clk), .rst(rst), .en(cnt_en), .run(run_w), .start_go(start_go_w),
    .zero_tick(ztick_w), .duty_wr(duty_wr), .duty_wdata(duty_wdata),
    .cnt(slv_count), .load_val(slv_ld_w), .active(active_w)
  );

  pwm_out_stage u_out (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_in(cfg_w),
    .active(active_w), .pin(pwm_out), .pin_oe(pwm_oe)
  );

endmodule

// File: rtl/pwm_pair_checker.sv
`timescale 1ns/1ps
module pwm_pair_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         start_go,
  input logic         run,
  input logic         tick,
  input logic         zero_tick,
  input logic         mst_irq,
  input logic [W-1:0] mst_count,
  input logic [W-1:0] slv_count,
  input logic [W-1:0] slv_ld
);

  a_r2_irq_after_start: assert property (@(posedge clk) disable iff (rst)
    start_go |=> mst_irq);

  a_r3_irq_after_zero: assert property (@(posedge clk) disable iff (rst)
    zero_tick |=> mst_irq);

  a_r3_irq_only_from_tick: assert property (@(posedge clk) disable iff (rst)
    mst_irq |-> $past(tick));

  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_en && !start_go) |=> $stable(mst_count));

  a_r4_slave_reload: assert property (@(posedge clk) disable iff (rst)
    tick |=> (slv_count == $past(slv_ld)));

  a_r4_slave_parks: assert property (@(posedge clk) disable iff (rst)
    (slv_count == '0 && !tick) |=> (slv_count == '0));

  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_go) |=> ($stable(mst_count) && $stable(slv_count)));

endmodule

bind pwm_pair_timer pwm_pair_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .start_go(start_go_w),
  .run(run_w), .tick(tick_w), .zero_tick(ztick_w), .mst_irq(mst_irq),
  .mst_count(mst_count), .slv_count(slv_count), .slv_ld(slv_ld_w)
);

// File: tb/test_pwm_pair_timer.sv
`timescale 1ns/1ps
module test_pwm_pair_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, cnt_en = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic per_wr = 1'b0, duty_wr = 1'b0, cfg_wr = 1'b0;
  logic cfg_oe = 1'b0, cfg_pol = 1'b0, cfg_lvl = 1'b0;
  logic [W-1:0] per_wdata = '0, duty_wdata = '0;
  logic [W-1:0] mst_count, slv_count;
  logic mst_irq, pwm_out, pwm_oe;

  pwm_pair_timer #(.CNT_W(W)) i_pwm_pair_timer (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .start_req(start_req),
    .stop_req(stop_req), .per_wr(per_wr), .per_wdata(per_wdata),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata), .cfg_wr(cfg_wr),
    .cfg_oe(cfg_oe), .cfg_pol(cfg_pol), .cfg_lvl(cfg_lvl),
    .mst_count(mst_count), .slv_count(slv_count), .mst_irq(mst_irq),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated on each rising edge.
  int m_m = 0, m_s = 0, m_pact = 0, m_dact = 0, m_preg = 0, m_dreg = 0;
  bit m_run = 0, m_irq = 0, m_oe = 0, m_pol = 0, m_lvl = 0;

  always @(posedge clk) begin
    bit st, zt;
    int o_p, o_d, o_pa, o_da, exp_out;
    if (rst) begin
      m_m = 0; m_s = 0; m_pact = 0; m_dact = 0; m_preg = 0; m_dreg = 0;
      m_run = 0; m_irq = 0; m_oe = 0; m_pol = 0; m_lvl = 0;
    end else begin
      st = start_req && !stop_req;
      zt = m_run && cnt_en && (m_m == 0);
      o_p = m_preg; o_d = m_dreg; o_pa = m_pact; o_da = m_dact;
      if (st) m_m = o_p;
      else if (m_run && cnt_en) m_m = (m_m == 0) ? o_pa : m_m - 1;
      if (st) m_s = o_d;
      else if (zt) m_s = o_da;
      else if (m_run && cnt_en && m_s != 0) m_s = m_s - 1;
      if (st || zt) begin m_pact = o_p; m_dact = o_d; end
      m_irq = st || zt;
      if (stop_req) m_run = 0; else if (start_req) m_run = 1;
      if (per_wr) m_preg = int'(per_wdata);
      if (duty_wr) m_dreg = int'(duty_wdata);
      if (cfg_wr) begin m_oe = cfg_oe; m_pol = cfg_pol; m_lvl = cfg_lvl; end
    end
    #1;
    exp_out = m_oe ? int'((m_s != 0) ^ m_pol) : int'(m_lvl);
    check(int'(mst_count) == m_m, "R3 model mst_count", int'(mst_count), m_m);
    check(int'(slv_count) == m_s, "R4 model slv_count", int'(slv_count), m_s);
    check(int'(mst_irq) == int'(m_irq), "R2 model mst_irq", int'(mst_irq), int'(m_irq));
    check(int'(pwm_out) == exp_out, "R5 model pwm_out", int'(pwm_out), exp_out);
    check(int'(pwm_oe) == int'(m_oe), "R9 model pwm_oe", int'(pwm_oe), int'(m_oe));
  end

  task automatic sample(); @(posedge clk); #1; endtask

  task automatic wait_irq();
    sample();
    while (!mst_irq) sample();
  endtask

  task automatic set_period(input int v);
    @(negedge clk); per_wr = 1; per_wdata = W'(v);
    @(negedge clk); per_wr = 0;
  endtask

  task automatic set_duty(input int v);
    @(negedge clk); duty_wr = 1; duty_wdata = W'(v);
    @(negedge clk); duty_wr = 0;
  endtask

  task automatic set_cfg(input bit oe, input bit pol, input bit lvl);
    @(negedge clk); cfg_wr = 1; cfg_oe = oe; cfg_pol = pol; cfg_lvl = lvl;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
  endtask

  // Counts high samples over n samples, beginning at the current one.
  task automatic count_hi(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) c++;
      if (i < n - 1) sample();
    end
  endtask

  task automatic irq_gap(output int n);
    n = 0;
    do begin sample(); n++; end while (!mst_irq);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1-to-R9 run actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c, g;
    logic [W-1:0] hold_m, hold_s;
    logic hold_o;
    repeat (4) @(negedge clk);
    rst = 0;
    sample();
    check(mst_count == 0 && slv_count == 0, "R1 counters after reset", int'(mst_count), 0);
    check(pwm_out == 0 && pwm_oe == 0, "R1 pins after reset", int'(pwm_out), 0);
    @(negedge clk); cnt_en = 1;
    repeat (5) sample();
    check(mst_count == 0, "R1 no counting before start", int'(mst_count), 0);

    // Steady enable, P=9, D=4.
    set_period(9); set_duty(4); set_cfg(1, 0, 0);
    pulse_start();
    wait_irq(); wait_irq();
    count_hi(10, c);
    check(c == 4, "R5 active count D=4 P=9", c, 4);
    wait_irq(); irq_gap(g);
    check(g == 10, "R3 period P+1 with P=9", g, 10);

    // Irregular count-clock enable; model compares every cycle.
    begin
      logic [7:0] lf = 8'hA5;
      for (int i = 0; i < 120; i++) begin
        @(negedge clk);
        cnt_en = lf[0] | lf[3];
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      end
      @(negedge clk); cnt_en = 1;
    end

    // Duty extremes.
    set_duty(0);
    wait_irq(); wait_irq();
    count_hi(10, c);
    check(c == 0, "R5 duty zero never active", c, 0);
    set_duty(15);
    wait_irq(); wait_irq();
    count_hi(20, c);
    check(c == 20, "R5 duty above period always active", c, 20);

    // Period rewrite mid-run lands one tick late.
    set_duty(2);
    wait_irq();
    set_period(5);
    wait_irq(); irq_gap(g);
    check(g == 10, "R6 old period still used after capture tick", g, 10);
    irq_gap(g);
    check(g == 6, "R6 new period used after following tick", g, 6);

    // Inverted polarity: P=5, D=2 gives 4 high of 6.
    set_cfg(1, 1, 0);
    wait_irq();
    count_hi(6, c);
    check(c == 4, "R8 active-low output high count", c, 4);

    // Stop holds everything; stop wins over start.
    wait_irq(); sample();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    sample();
    hold_m = mst_count; hold_s = slv_count; hold_o = pwm_out;
    repeat (8) sample();
    check(mst_count == hold_m && slv_count == hold_s, "R7 counters hold", int'(mst_count), int'(hold_m));
    check(pwm_out == hold_o, "R7 output holds", int'(pwm_out), int'(hold_o));
    @(negedge clk); start_req = 1; stop_req = 1;
    @(negedge clk); start_req = 0; stop_req = 0;
    repeat (3) sample();
    check(mst_count == hold_m && mst_irq == 0, "R7 stop wins over start", int'(mst_count), int'(hold_m));

    // Software level with output disabled.
    set_cfg(0, 0, 1);
    sample();
    check(pwm_out == 1 && pwm_oe == 0, "R9 software level 1", int'(pwm_out), 1);
    set_cfg(0, 1, 0);
    sample();
    check(pwm_out == 0 && pwm_oe == 0, "R9 software level 0", int'(pwm_out), 0);

    // Restart: loads from written values, interrupt on next cycle.
    set_cfg(1, 0, 0);
    @(negedge clk); start_req = 1;
    @(posedge clk); #1;
    check(mst_irq == 1, "R2 start interrupt", int'(mst_irq), 1);
    check(mst_count == 5 && slv_count == 2, "R2 start loads counters", int'(mst_count), 5);
    @(negedge clk); start_req = 0;
    repeat (20) sample();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule